// File: doc/BRIEF.md
# Six-Floor Elevator Controller

This block is the control core of a six-floor elevator. It takes the hall call buttons (an up button on floors 1 to 5, a down button on floors 2 to 6), the six car buttons and a one-second tick enable. It holds every press until that floor is served, moves the car one floor per tick, and times the door. It reports the car position, the door, the travel direction and the controller state. Software, displays and the tick divider sit outside.

Calls are packed into three six-bit vectors, one bit per floor. The up-call vector has a constant zero at the top floor and the down-call vector has a constant zero at the bottom floor. A one-hot state machine compares these vectors with the one-hot car position. The states are WAIT (parked, door shut), UP and DOWN (travelling), UPSTOP and DOWNSTOP (halted at a floor on the way up or down), OPENDOOR and CLOSEDOOR.

The named transitions, all taken only on a tick, are:
- WAIT→OPENDOOR: a call at the parked floor.
- WAIT→UP: a call above.
- WAIT→DOWN: a call below.
- UP→UPSTOP and DOWN→DOWNSTOP: arrival at a floor worth stopping at.
- UPSTOP→OPENDOOR and DOWNSTOP→OPENDOOR: always.
- OPENDOOR→CLOSEDOOR: after the hold time.
- CLOSEDOOR→UP, CLOSEDOOR→DOWN or CLOSEDOOR→WAIT: the dispatch decision.

Top module: `lift_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after it, the floor output is 000001 (floor 1), the state is WAIT, the door flag is 0 and the direction is 00. Reset is synchronous and overrides all other inputs.
- R2: The state output is one-hot: WAIT=0000001, UP=0000010, DOWN=0000100, UPSTOP=0001000, DOWNSTOP=0010000, OPENDOOR=0100000, CLOSEDOOR=1000000. The floor output is one-hot, with bit k meaning floor k+1.
- R3: In UP or DOWN, each tick moves the car exactly one floor up or down. In every other state the floor output does not change.
- R4: The direction output is 01 while serving upward, 10 while serving downward and 00 when stationary. It is always 00 in WAIT, and it is 00 when the door opens from WAIT at the parked floor.
- R5: When rising, the car halts (UPSTOP) at the first floor that has a car call or an up call. It also halts at a floor with a down call when no call of any kind is pending above that floor. It passes any other floor.
- R6: When falling, the car halts (DOWNSTOP) at the first floor that has a car call or a down call. It also halts at a floor with an up call when no call is pending below that floor.
- R7: One tick after UPSTOP or DOWNSTOP the state is OPENDOOR. The door flag is 1 only in OPENDOOR. The door stays open for 4 ticks, then the state is CLOSEDOOR.
- R8: From CLOSEDOOR, the car continues in its current direction while calls remain that way, otherwise reverses, otherwise enters WAIT. From WAIT, or after an open from WAIT, calls above take precedence over calls below.
- R9: In WAIT, a call at the parked floor leads on the next tick to OPENDOOR without moving.
- R10: A one-cycle press is held until served. While the door is open, the car call at that floor is cleared. The hall call matching the direction is also cleared, as is the opposite one when no calls lie beyond the floor; both are cleared when the direction is 00. A press at the open floor is absorbed and does not reopen the door.
- R11: State, floor and direction change only on cycles where the tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second step enable |
| hall_up_i | input | 5 | Up call buttons, bit k = floor k+1 |
| hall_dn_i | input | 5 | Down call buttons, bit k = floor k+2 |
| car_req_i | input | 6 | Car buttons, bit k = floor k+1 |
| floor_o | output | 6 | One-hot car position |
| door_o | output | 1 | 1 while the door is open |
| dir_o | output | 2 | 01 up, 10 down, 00 stationary |
| state_o | output | 7 | One-hot controller state |

## Verification
The properties assume that the tick is a single-cycle pulse train with arbitrary spacing. They also assume that buttons may be pressed on any cycle, at any floor and in any combination, since the held-call logic must keep the car inside the shaft regardless. The stimulus keeps the tick random at about one cycle in three and the presses sparse and random. Rare random resets are mixed in. Directed runs cover the rise past a down call, the reversal, and a press absorbed while the door is open.

// File: rtl/lift_pkg.sv
package lift_pkg;

    typedef enum logic [6:0] {
        ST_WAIT   = 7'b0000001,
        ST_UP     = 7'b0000010,
        ST_DOWN   = 7'b0000100,
        ST_UPSTOP = 7'b0001000,
        ST_DNSTOP = 7'b0010000,
        ST_OPEN   = 7'b0100000,
        ST_CLOSE  = 7'b1000000
    } lift_state_t;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DN   = 2'b10
    } lift_dir_t;

endpackage

// File: rtl/lift_req.sv
// Held call registers: a press sets a bit, service at the floor clears it.
module lift_req #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_car,
    input  logic [N-1:0] set_up,
    input  logic [N-1:0] set_dn,
    input  logic [N-1:0] clr_car,
    input  logic [N-1:0] clr_up,
    input  logic [N-1:0] clr_dn,
    output logic [N-1:0] pend_car,
    output logic [N-1:0] pend_up,
    output logic [N-1:0] pend_dn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_car <= '0;
            pend_up  <= '0;
            pend_dn  <= '0;
        end else begin
            pend_car <= (pend_car | set_car) & ~clr_car;
            pend_up  <= (pend_up  | set_up)  & ~clr_up;
            pend_dn  <= (pend_dn  | set_dn)  & ~clr_dn;
        end
    end

endmodule

// File: rtl/lift_scan.sv
// Calls relative to the current floor.
module lift_scan #(
    parameter int N = 6
) (
    input  logic [N-1:0] pos,
    input  logic [N-1:0] car,
    input  logic [N-1:0] up,
    input  logic [N-1:0] dn,
    output logic         above,
    output logic         below,
    output logic         here
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] all_calls;
    logic [N-1:0] pos_sh;
    logic [N-1:0] at_or_below;
    logic [N-1:0] strictly_below;

    always_comb begin
        all_calls      = car | up | dn;
        pos_sh         = pos << 1;
        at_or_below    = pos_sh - ONE;
        strictly_below = pos - ONE;
        above          = |(all_calls & ~at_or_below);
        below          = |(all_calls & strictly_below);
        here           = |(all_calls & pos);
    end

endmodule

// File: rtl/lift_stop_test.sv
// Decides whether a floor reached while travelling deserves a halt.
module lift_stop_test #(
    parameter int N      = 6,
    parameter bit RISING = 1'b1
) (
    input  logic [N-1:0] pos,
    input  logic [N-1:0] car,
    input  logic [N-1:0] up,
    input  logic [N-1:0] dn,
    output logic         stop
);

    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] all_calls;
    assign all_calls = car | up | dn;

    generate
        if (RISING) begin : g_rise
            logic [N-1:0] pos_sh;
            logic [N-1:0] at_or_below;
            logic         beyond;
            always_comb begin
                pos_sh      = pos << 1;
                at_or_below = pos_sh - ONE;
                beyond      = |(all_calls & ~at_or_below);
                stop        = (|(pos & (car | up))) | ((|(pos & dn)) & ~beyond);
            end
        end else begin : g_fall
            logic [N-1:0] strictly_below;
            logic         beyond;
            always_comb begin
                strictly_below = pos - ONE;
                beyond         = |(all_calls & strictly_below);
                stop           = (|(pos & (car | dn))) | ((|(pos & up)) & ~beyond);
            end
        end
    endgenerate

endmodule

// File: rtl/lift_door_timer.sv
// Counts ticks while the door is open; flags the last one.
module lift_door_timer #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    output logic done
);

    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CW-1:0] cnt;

    assign done = run & tick & (cnt == CW'(HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
    import lift_pkg::*;
#(
    parameter int FLOORS     = 6,
    parameter int HOLD_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [FLOORS-2:0] hall_up_i,
    input  logic [FLOORS-2:0] hall_dn_i,
    input  logic [FLOORS-1:0] car_req_i,
    output logic [FLOORS-1:0] floor_o,
    output logic              door_o,
    output logic [1:0]        dir_o,
    output logic [6:0]        state_o
);

    localparam logic [FLOORS-1:0] BOTTOM = {{(FLOORS-1){1'b0}}, 1'b1};

    lift_state_t       state_q, state_d;
    lift_dir_t         dir_q, dir_d;
    logic [FLOORS-1:0] floor_q, floor_d;

    logic [FLOORS-1:0] set_up, set_dn;
    logic [FLOORS-1:0] pend_car, pend_up, pend_dn;
    logic [FLOORS-1:0] clr_car, clr_up, clr_dn;
    logic [FLOORS-1:0] pos_up, pos_dn;
    logic              any_above, any_below, any_here;
    logic              stop_rise, stop_fall;
    logic              door_done;

    // Floor-aligned packing; floors without such a button read zero.
    assign set_up = {1'b0, hall_up_i};
    assign set_dn = {hall_dn_i, 1'b0};
    assign pos_up = floor_q << 1;
    assign pos_dn = floor_q >> 1;

    lift_req #(.N(FLOORS)) u_req (
        .clk      (clk),
        .rst      (rst),
        .set_car  (car_req_i),
        .set_up   (set_up),
        .set_dn   (set_dn),
        .clr_car  (clr_car),
        .clr_up   (clr_up),
        .clr_dn   (clr_dn),
        .pend_car (pend_car),
        .pend_up  (pend_up),
        .pend_dn  (pend_dn)
    );

    lift_scan #(.N(FLOORS)) u_scan (
        .pos   (floor_q),
        .car   (pend_car),
        .up    (pend_up),
        .dn    (pend_dn),
        .above (any_above),
        .below (any_below),
        .here  (any_here)
    );

    lift_stop_test #(.N(FLOORS), .RISING(1'b1)) u_stop_rise (
        .pos  (pos_up),
        .car  (pend_car),
        .up   (pend_up),
        .dn   (pend_dn),
        .stop (stop_rise)
    );

    lift_stop_test #(.N(FLOORS), .RISING(1'b0)) u_stop_fall (
        .pos  (pos_dn),
        .car  (pend_car),
        .up   (pend_up),
        .dn   (pend_dn),
        .stop (stop_fall)
    );

    lift_door_timer #(.HOLD(HOLD_TICKS)) u_door (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .run  (state_q == ST_OPEN),
        .done (door_done)
    );

    // Service clears at the open floor.
    always_comb begin
        clr_car = '0;
        clr_up  = '0;
        clr_dn  = '0;
        if (state_q == ST_OPEN) begin
            clr_car = floor_q;
            unique case (dir_q)
                DIR_UP: begin
                    clr_up = floor_q;
                    if (!any_above) clr_dn = floor_q;
                end
                DIR_DN: begin
                    clr_dn = floor_q;
                    if (!any_below) clr_up = floor_q;
                end
                default: begin
                    clr_up = floor_q;
                    clr_dn = floor_q;
                end
            endcase
        end
    end

    // Next state: every move happens on a tick.
    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        floor_d = floor_q;
        if (tick) begin
            unique case (state_q)
                ST_WAIT: begin
                    if (any_here) begin
                        state_d = ST_OPEN;
                        dir_d   = DIR_IDLE;
                    end else if (any_above) begin
                        state_d = ST_UP;
                        dir_d   = DIR_UP;
                    end else if (any_below) begin
                        state_d = ST_DOWN;
                        dir_d   = DIR_DN;
                    end else begin
                        dir_d   = DIR_IDLE;
                    end
                end
                ST_UP: begin
                    floor_d = pos_up;
                    state_d = stop_rise ? ST_UPSTOP : ST_UP;
                end
                ST_DOWN: begin
                    floor_d = pos_dn;
                    state_d = stop_fall ? ST_DNSTOP : ST_DOWN;
                end
                ST_UPSTOP, ST_DNSTOP: begin
                    state_d = ST_OPEN;
                end
                ST_OPEN: begin
                    if (door_done) state_d = ST_CLOSE;
                end
                ST_CLOSE: begin
                    if (dir_q == DIR_DN) begin
                        if (any_below) begin
                            state_d = ST_DOWN;
                        end else if (any_above) begin
                            state_d = ST_UP;
                            dir_d   = DIR_UP;
                        end else begin
                            state_d = ST_WAIT;
                            dir_d   = DIR_IDLE;
                        end
                    end else begin
                        if (any_above) begin
                            state_d = ST_UP;
                            dir_d   = DIR_UP;
                        end else if (any_below) begin
                            state_d = ST_DOWN;
                            dir_d   = DIR_DN;
                        end else begin
                            state_d = ST_WAIT;
                            dir_d   = DIR_IDLE;
                        end
                    end
                end
                default: begin
                    state_d = ST_WAIT;
                    dir_d   = DIR_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
            dir_q   <= DIR_IDLE;
            floor_q <= BOTTOM;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            floor_q <= floor_d;
        end
    end

    // Outputs.
    always_comb begin
        state_o = state_q;
        dir_o   = dir_q;
        floor_o = floor_q;
        door_o  = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk
    import lift_pkg::*;
#(
    parameter int FLOORS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [FLOORS-1:0] floor_o,
    input logic              door_o,
    input logic [1:0]        dir_o,
    input logic [6:0]        state_o
);

    p_state_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(state_o) == 1);

    p_floor_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(floor_o) == 1);

    p_climb_one_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && state_o == ST_UP) |=> floor_o == ($past(floor_o) << 1));

    p_parked_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o != ST_UP && state_o != ST_DOWN) |=> $stable(floor_o));

    p_wait_idle_r4: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_WAIT |-> dir_o == 2'b00);

    p_no_rise_at_top_r5: assert property (@(posedge clk) disable iff (rst)
        floor_o[FLOORS-1] |-> state_o != ST_UP);

    p_no_fall_at_bottom_r6: assert property (@(posedge clk) disable iff (rst)
        floor_o[0] |-> state_o != ST_DOWN);

    p_stop_opens_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && (state_o == ST_UPSTOP || state_o == ST_DNSTOP)) |=> (state_o == ST_OPEN && door_o));

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(state_o) && $stable(floor_o) && $stable(dir_o)));

endmodule

bind lift_ctrl lift_ctrl_chk #(.FLOORS(FLOORS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .floor_o (floor_o),
    .door_o  (door_o),
    .dir_o   (dir_o),
    .state_o (state_o)
);

// File: tb/lift_ctrl_test.sv
`timescale 1ns/1ps
module lift_ctrl_test;

    localparam int N    = 6;
    localparam int HOLD = 4;

    localparam logic [6:0] S_WAIT = 7'b0000001, S_UP = 7'b0000010, S_DOWN = 7'b0000100,
                           S_UPS  = 7'b0001000, S_DNS = 7'b0010000, S_OPEN = 7'b0100000,
                           S_CLOSE = 7'b1000000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic [N-2:0] hall_up = '0;
    logic [N-2:0] hall_dn = '0;
    logic [N-1:0] car = '0;
    logic [N-1:0] floor_o;
    logic         door_o;
    logic [1:0]   dir_o;
    logic [6:0]   state_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lift_ctrl #(.FLOORS(N), .HOLD_TICKS(HOLD)) uut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hall_up_i (hall_up),
        .hall_dn_i (hall_dn),
        .car_req_i (car),
        .floor_o   (floor_o),
        .door_o    (door_o),
        .dir_o     (dir_o),
        .state_o   (state_o)
    );

    // Reference model built from the requirements.
    int         m_floor;
    bit [N-1:0] m_car, m_up, m_dn;
    logic [6:0] m_state;
    logic [1:0] m_dir;
    int         m_cnt;

    function automatic bit halt_here(int f, bit rising);
        bit [N-1:0] all;
        bit beyond;
        all = m_car | m_up | m_dn;
        beyond = 1'b0;
        for (int i = 0; i < N; i++)
            if (all[i] && (rising ? (i > f) : (i < f))) beyond = 1'b1;
        if (rising) return m_car[f] | m_up[f] | (m_dn[f] & ~beyond);
        return m_car[f] | m_dn[f] | (m_up[f] & ~beyond);
    endfunction

    task automatic model_step();
        bit [N-1:0] su, sd, all, cc, cu, cd;
        bit ab, be, hr;
        int nf, ncnt;
        logic [6:0] ns;
        logic [1:0] nd;
        if (rst) begin
            m_floor = 0; m_car = '0; m_up = '0; m_dn = '0;
            m_state = S_WAIT; m_dir = 2'b00; m_cnt = 0;
            return;
        end
        su = {1'b0, hall_up};
        sd = {hall_dn, 1'b0};
        all = m_car | m_up | m_dn;
        ab = 1'b0; be = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (all[i] && i > m_floor) ab = 1'b1;
            if (all[i] && i < m_floor) be = 1'b1;
        end
        hr = all[m_floor];
        cc = '0; cu = '0; cd = '0;
        if (m_state == S_OPEN) begin
            cc[m_floor] = 1'b1;
            if (m_dir == 2'b01) begin cu[m_floor] = 1'b1; if (!ab) cd[m_floor] = 1'b1; end
            else if (m_dir == 2'b10) begin cd[m_floor] = 1'b1; if (!be) cu[m_floor] = 1'b1; end
            else begin cu[m_floor] = 1'b1; cd[m_floor] = 1'b1; end
        end
        ns = m_state; nd = m_dir; nf = m_floor;
        if (m_state != S_OPEN) ncnt = 0;
        else if (tick) ncnt = (m_cnt == HOLD - 1) ? 0 : m_cnt + 1;
        else ncnt = m_cnt;
        if (tick) begin
            case (m_state)
                S_WAIT: begin
                    if (hr) begin ns = S_OPEN; nd = 2'b00; end
                    else if (ab) begin ns = S_UP; nd = 2'b01; end
                    else if (be) begin ns = S_DOWN; nd = 2'b10; end
                    else nd = 2'b00;
                end
                S_UP: begin nf = m_floor + 1; ns = halt_here(nf, 1'b1) ? S_UPS : S_UP; end
                S_DOWN: begin nf = m_floor - 1; ns = halt_here(nf, 1'b0) ? S_DNS : S_DOWN; end
                S_UPS, S_DNS: ns = S_OPEN;
                S_OPEN: if (m_cnt == HOLD - 1) ns = S_CLOSE;
                S_CLOSE: begin
                    if (m_dir == 2'b10) begin
                        if (be) ns = S_DOWN;
                        else if (ab) begin ns = S_UP; nd = 2'b01; end
                        else begin ns = S_WAIT; nd = 2'b00; end
                    end else begin
                        if (ab) begin ns = S_UP; nd = 2'b01; end
                        else if (be) begin ns = S_DOWN; nd = 2'b10; end
                        else begin ns = S_WAIT; nd = 2'b00; end
                    end
                end
                default: ns = S_WAIT;
            endcase
        end
        m_car = (m_car | car) & ~cc;
        m_up  = (m_up | su) & ~cu;
        m_dn  = (m_dn | sd) & ~cd;
        m_state = ns; m_dir = nd; m_floor = nf; m_cnt = ncnt;
    endtask

    always @(posedge clk) model_step();

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the model.
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 state vs model", 32'(state_o), 32'(m_state));
            check("R3 floor vs model", 32'(floor_o), 32'(1 << m_floor));
            check("R7 door vs model", 32'(door_o), 32'(m_state == S_OPEN));
            check("R4 dir vs model", 32'(dir_o), 32'(m_dir));
        end
    end

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 floor after reset", 32'(floor_o), 32'h01);
        check("R1 state after reset", 32'(state_o), 32'(S_WAIT));
        check("R1 door after reset", 32'(door_o), 32'h0);
        check("R1 dir after reset", 32'(dir_o), 32'h0);

        // Single-cycle press of car button for floor 4 is held (R10).
        car[3] = 1'b1; @(negedge clk); car = '0;
        repeat (3) @(negedge clk);
        check("R11 no move without tick", 32'(state_o), 32'(S_WAIT));
        do_tick();
        check("R2 UP code", 32'(state_o), 32'h02);
        check("R4 dir up", 32'(dir_o), 32'h1);
        check("R10 held press started trip", 32'(floor_o), 32'h01);
        ticks(2);
        check("R3 two floors in two ticks", 32'(floor_o), 32'h04);
        do_tick();
        check("R5 halt at car call", 32'(state_o), 32'(S_UPS));
        check("R5 floor 4", 32'(floor_o), 32'h08);
        do_tick();
        check("R7 door opens", 32'(door_o), 32'h1);
        ticks(3);
        check("R7 door still open", 32'(door_o), 32'h1);
        do_tick();
        check("R7 door closing", 32'(state_o), 32'(S_CLOSE));
        do_tick();
        check("R8 park when idle", 32'(state_o), 32'(S_WAIT));
        check("R8 park floor", 32'(floor_o), 32'h08);

        // Down calls on floors 5 and 6: rise past 5, reverse at 6.
        hall_dn[3] = 1'b1; hall_dn[4] = 1'b1; @(negedge clk); hall_dn = '0;
        ticks(2);
        check("R5 pass down call with call above", 32'(state_o), 32'(S_UP));
        do_tick();
        check("R5 halt at topmost down call", 32'(state_o), 32'(S_UPS));
        check("R5 floor 6", 32'(floor_o), 32'h20);
        ticks(6);
        check("R8 reverse after upward work", 32'(state_o), 32'(S_DOWN));
        check("R8 dir down", 32'(dir_o), 32'h2);
        do_tick();
        check("R6 halt at down call", 32'(state_o), 32'(S_DNS));
        check("R6 floor 5", 32'(floor_o), 32'h10);
        ticks(7);
        check("R8 wait at floor 5", 32'(state_o), 32'(S_WAIT));

        // Call at the parked floor.
        car[4] = 1'b1; @(negedge clk); car = '0;
        do_tick();
        check("R9 open in place", 32'(state_o), 32'(S_OPEN));
        check("R9 no move", 32'(floor_o), 32'h10);
        check("R9 dir idle", 32'(dir_o), 32'h0);
        car[4] = 1'b1; @(negedge clk); car = '0;
        ticks(5);
        check("R10 press absorbed while open", 32'(state_o), 32'(S_WAIT));
        check("R10 door shut", 32'(door_o), 32'h0);

        // Random traffic.
        for (int c = 0; c < 6000; c++) begin
            tick = ($urandom_range(0, 2) == 0);
            rst  = ($urandom_range(0, 2999) == 0);
            for (int i = 0; i < N - 1; i++) begin
                hall_up[i] = ($urandom_range(0, 79) == 0);
                hall_dn[i] = ($urandom_range(0, 79) == 0);
            end
            for (int i = 0; i < N; i++) car[i] = ($urandom_range(0, 79) == 0);
            @(negedge clk);
        end
        rst = 1'b0; tick = 1'b0; hall_up = '0; hall_dn = '0; car = '0;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule